// File: doc/BRIEF.md
# Dual-Channel I/O Write Snoop Controller

This block sits beside a decoded host I/O write bus and watches for writes to two port addresses that firmware programs. When the host writes to a watched port, the block copies the data byte into that channel's capture byte and marks the channel as pending. A typical use is tracking boot-progress codes that system firmware posts to a debug port. The block reports every matching write, including one that repeats the previous value.

A management processor services both channels through one interrupt line and a small 32-bit register interface. Reads are combinational from `reg_addr`. A write takes effect on the clock edge at which `reg_we` is high. The processor reads the capture bytes and then acknowledges each channel by writing 1 to its status bit.

Each channel is a two-state machine. The states are `CH_IDLE` (nothing pending) and `CH_PEND` (a capture is waiting). The transitions are:
- `CH_IDLE` goes to `CH_PEND` on a capture hit.
- `CH_PEND` stays in `CH_PEND` on a hit, and the new byte overwrites the old one.
- `CH_PEND` goes to `CH_IDLE` when a status clear arrives and no hit occurs in the same cycle.
- `CH_IDLE` stays in `CH_IDLE` in every other case, and so does `CH_PEND`.

A capture hit needs all of the following: the host write strobe is high, the write address equals the channel's port, and both of the channel's enables are set.

Top module: `iow_snoop`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: A host write to channel c's port while channel c is enabled does two things. From the next cycle, status register 0x04 bit c reads 1. Capture register 0x14 returns the byte in bits [7:0] for channel 0 and in bits [15:8] for channel 1.
- R3: A channel captures only if both of its enables are set. The control enable is bit 0 of register 0x00 for channel 0 and bit 2 for channel 1. The data enable is bit 14 of register 0x80 for channel 0 and bit 15 for channel 1. The channel also needs the write address to equal its port. Without all of these, neither the status bit nor the capture byte changes.
- R4: Writing 1 to a bit of status register 0x04 clears that bit. Writing 0 to a bit leaves it unchanged.
- R5: `irq` is high while any channel has its status bit set together with its interrupt enable. The interrupt enable is bit 1 of register 0x00 for channel 0 and bit 3 for channel 1. `irq` stays high until that condition ends.
- R6: Each matching write sets the status bit, even when the host writes the same value again after a clear.
- R7: A new capture overwrites the channel's byte while its status bit is still set, and the bit stays set.
- R8: If a capture hit and a status clear for the same channel fall in one cycle, the status bit ends up set.
- R9: If both channels are programmed to the same port, one matching write captures into both channels.
- R10: Port register 0x10 is read/write. It holds channel 0's port in bits [15:0] and channel 1's port in bits [31:16].
- R11: Offsets not listed above read 0, and writes to them are ignored. Capture register 0x14 is read-only. Unused bits of registers 0x00 and 0x80 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host I/O write strobe, one cycle per write |
| host_addr | input | 16 | Host I/O port address |
| host_data | input | 8 | Host write data byte |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Interrupt to the management processor |

## Verification
If a channel's state machine is stuck in, or wrongly leaves, `CH_PEND`, the error appears at the ports one cycle after the host write or status clear. The status register read shows the wrong bit, and `irq` follows the same value in that cycle. A corrupted capture byte or port register shows up on the next read of 0x14 or 0x10. The same-cycle race and the shared-port case are the places where a wrong priority or a missing match would otherwise stay hidden.

// File: rtl/iosnp_pkg.sv
package iosnp_pkg;
    localparam int NUM_CH   = 2;
    localparam int REG_AW   = 8;
    localparam int REG_DW   = 32;
    localparam int DEN_BIT0 = 14;

    localparam logic [REG_AW-1:0] OFS_CTRL = 8'h00;
    localparam logic [REG_AW-1:0] OFS_STAT = 8'h04;
    localparam logic [REG_AW-1:0] OFS_PORT = 8'h10;
    localparam logic [REG_AW-1:0] OFS_DATA = 8'h14;
    localparam logic [REG_AW-1:0] OFS_DEN  = 8'h80;

    typedef enum logic [0:0] {
        CH_IDLE = 1'b0,
        CH_PEND = 1'b1
    } ch_state_e;
endpackage

// File: rtl/snoop_chan.sv
module snoop_chan
    import iosnp_pkg::*;
#(
    parameter int PORT_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [PORT_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_data,
    input  logic              cap_en,
    input  logic [PORT_W-1:0] port_sel,
    input  logic              clr,
    output logic              pending,
    output logic [DATA_W-1:0] data_q
);
    ch_state_e state_q, state_d;
    logic      hit;

    assign hit = host_wr && cap_en && (host_addr == port_sel);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (hit)         state_d = CH_PEND;
            CH_PEND: if (clr && !hit) state_d = CH_IDLE;
            default:                  state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   data_q <= '0;
        else if (hit) data_q <= host_data;
    end

    assign pending = (state_q == CH_PEND);

    // R2: a hit leaves the channel pending
    p_capture_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> pending);
    // R7: the byte captured is the one written
    p_data_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (data_q == $past(host_data)));
    // R3: a disabled channel keeps its byte
    p_disabled_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(data_q));
    // R3: a mismatched address keeps the byte
    p_mismatch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr != port_sel) |=> $stable(data_q));
    // R4: a clear without a hit returns to idle
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !pending);
    // R8: a hit wins over a clear in the same cycle
    p_race_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && hit) |=> pending);
endmodule

// File: rtl/snoop_regs.sv
module snoop_regs
    import iosnp_pkg::*;
#(
    parameter int PORT_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [REG_AW-1:0]        reg_addr,
    input  logic                     reg_we,
    input  logic [REG_DW-1:0]        reg_wdata,
    output logic [REG_DW-1:0]        reg_rdata,
    input  logic [NUM_CH-1:0]        ch_pend,
    input  logic [NUM_CH*DATA_W-1:0] ch_data,
    output logic [NUM_CH-1:0]        cap_en,
    output logic [NUM_CH-1:0]        irq_en,
    output logic [NUM_CH*PORT_W-1:0] port_sel,
    output logic [NUM_CH-1:0]        clr
);
    localparam int CTRL_W = 2 * NUM_CH;

    logic [CTRL_W-1:0]        ctrl_q;
    logic [NUM_CH-1:0]        den_q;
    logic [NUM_CH*PORT_W-1:0] port_q;
    logic                     known;

    assign known = (reg_addr == OFS_CTRL) || (reg_addr == OFS_STAT) ||
                   (reg_addr == OFS_PORT) || (reg_addr == OFS_DATA) ||
                   (reg_addr == OFS_DEN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            den_q  <= '0;
            port_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == OFS_CTRL) ctrl_q <= reg_wdata[CTRL_W-1:0];
            if (reg_addr == OFS_DEN)  den_q  <= reg_wdata[DEN_BIT0 +: NUM_CH];
            if (reg_addr == OFS_PORT) port_q <= reg_wdata[NUM_CH*PORT_W-1:0];
        end
    end

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_en
            assign cap_en[c] = ctrl_q[2*c] & den_q[c];
            assign irq_en[c] = ctrl_q[2*c+1];
        end
    endgenerate

    assign port_sel = port_q;
    assign clr = (reg_we && reg_addr == OFS_STAT) ? reg_wdata[NUM_CH-1:0] : '0;

    always_comb begin
        unique case (reg_addr)
            OFS_CTRL: reg_rdata = REG_DW'(ctrl_q);
            OFS_STAT: reg_rdata = REG_DW'(ch_pend);
            OFS_PORT: reg_rdata = REG_DW'(port_q);
            OFS_DATA: reg_rdata = REG_DW'(ch_data);
            OFS_DEN:  reg_rdata = REG_DW'(den_q) << DEN_BIT0;
            default:  reg_rdata = '0;
        endcase
    end

    // R11: writes to unlisted offsets change no register
    p_undef_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !known) |=> ($stable(ctrl_q) && $stable(den_q) && $stable(port_q)));
    // R11: unlisted offsets read zero
    p_undef_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !known |-> (reg_rdata == '0));
    // R10: a port write is visible on the next cycle
    p_port_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFS_PORT) |=> (port_sel == $past(reg_wdata[NUM_CH*PORT_W-1:0])));
endmodule

// File: rtl/iow_snoop.sv
module iow_snoop
    import iosnp_pkg::*;
#(
    parameter int PORT_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [PORT_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_data,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              irq
);
    logic [NUM_CH-1:0]        pend;
    logic [NUM_CH*DATA_W-1:0] ch_data;
    logic [NUM_CH-1:0]        cap_en;
    logic [NUM_CH-1:0]        irq_en;
    logic [NUM_CH*PORT_W-1:0] port_sel;
    logic [NUM_CH-1:0]        clr;

    snoop_regs #(.PORT_W(PORT_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (reg_addr),
        .reg_we   (reg_we),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .ch_pend  (pend),
        .ch_data  (ch_data),
        .cap_en   (cap_en),
        .irq_en   (irq_en),
        .port_sel (port_sel),
        .clr      (clr)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            snoop_chan #(.PORT_W(PORT_W), .DATA_W(DATA_W)) u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .host_wr  (host_wr),
                .host_addr(host_addr),
                .host_data(host_data),
                .cap_en   (cap_en[c]),
                .port_sel (port_sel[c*PORT_W +: PORT_W]),
                .clr      (clr[c]),
                .pending  (pend[c]),
                .data_q   (ch_data[c*DATA_W +: DATA_W])
            );
        end
    endgenerate

    assign irq = |(pend & irq_en);

    // R5: no pending channel, no interrupt
    p_irq_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> !irq);
    // R5: interrupt holds without a clear or control write
    p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && clr == '0 && !(reg_we && reg_addr == OFS_CTRL)) |=> irq);
    // R9: shared port captures into both channels
    p_shared_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && (&cap_en) && port_sel[PORT_W-1:0] == port_sel[2*PORT_W-1:PORT_W]
         && host_addr == port_sel[PORT_W-1:0]) |=> (&pend));
endmodule

// File: tb/iow_snoop_bench.sv
`timescale 1ns/1ps
module iow_snoop_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [15:0] host_addr = '0;
    logic [7:0]  host_data = '0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_err = 0;

    always #2.5 clk = ~clk;

    iow_snoop u_iow_snoop (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_data(host_data), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic hw(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_data = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic cfg_std();
        wr(8'h00, 32'h0000_000F);
        wr(8'h80, 32'h0000_C000);
        wr(8'h10, 32'h0084_0080);
        wr(8'h04, 32'h3);
    endtask

    task automatic t_reset();
        rd_chk("R1 ctrl", 8'h00, 0);
        rd_chk("R1 stat", 8'h04, 0);
        rd_chk("R1 port", 8'h10, 0);
        rd_chk("R1 data", 8'h14, 0);
        rd_chk("R1 den",  8'h80, 0);
        chk("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_ports();
        wr(8'h10, 32'h1234_0080);
        rd_chk("R10 port readback", 8'h10, 32'h1234_0080);
    endtask

    task automatic t_capture();
        cfg_std();
        hw(16'h0080, 8'hA5);
        rd_chk("R2 ch0 stat", 8'h04, 32'h1);
        rd_chk("R2 ch0 data", 8'h14, 32'h0000_00A5);
        hw(16'h0084, 8'h3C);
        rd_chk("R2 ch1 stat", 8'h04, 32'h3);
        rd_chk("R2 ch1 data", 8'h14, 32'h0000_3CA5);
        chk("R5 irq both", {31'b0, irq}, 1);
    endtask

    task automatic t_w1c();
        wr(8'h04, 32'h1);
        rd_chk("R4 clear ch0", 8'h04, 32'h2);
        wr(8'h04, 32'h0);
        rd_chk("R4 write zero", 8'h04, 32'h2);
        chk("R5 irq ch1 held", {31'b0, irq}, 1);
        wr(8'h04, 32'h2);
        rd_chk("R4 clear ch1", 8'h04, 32'h0);
        chk("R5 irq low", {31'b0, irq}, 0);
    endtask

    task automatic t_irq_enable();
        wr(8'h00, 32'h5);
        hw(16'h0080, 8'h01);
        rd_chk("R5 stat no ie", 8'h04, 32'h1);
        chk("R5 irq masked", {31'b0, irq}, 0);
        wr(8'h00, 32'h7);
        @(negedge clk);
        chk("R5 irq unmasked", {31'b0, irq}, 1);
        wr(8'h04, 32'h3);
        wr(8'h00, 32'hF);
    endtask

    task automatic t_gating();
        wr(8'h00, 32'hE);
        hw(16'h0080, 8'h11);
        rd_chk("R3 ctrl off stat", 8'h04, 32'h0);
        rd_chk("R3 ctrl off data", 8'h14, 32'h0000_3C01);
        wr(8'h00, 32'hF);
        wr(8'h80, 32'h0000_8000);
        hw(16'h0080, 8'h22);
        rd_chk("R3 den off stat", 8'h04, 32'h0);
        rd_chk("R3 den off data", 8'h14, 32'h0000_3C01);
        wr(8'h80, 32'h0000_C000);
        hw(16'h0081, 8'h33);
        rd_chk("R3 mismatch stat", 8'h04, 32'h0);
        rd_chk("R3 mismatch data", 8'h14, 32'h0000_3C01);
    endtask

    task automatic t_repeat();
        hw(16'h0080, 8'h44);
        wr(8'h04, 32'h1);
        hw(16'h0080, 8'h44);
        rd_chk("R6 repeat value sets", 8'h04, 32'h1);
        wr(8'h04, 32'h1);
    endtask

    task automatic t_overwrite();
        hw(16'h0080, 8'h55);
        hw(16'h0080, 8'h66);
        rd_chk("R7 overwrite stat", 8'h04, 32'h1);
        rd_chk("R7 overwrite data", 8'h14, 32'h0000_3C66);
        wr(8'h04, 32'h1);
    endtask

    task automatic t_race();
        hw(16'h0084, 8'h77);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 16'h0084; host_data = 8'h88;
        reg_addr = 8'h04; reg_we = 1'b1; reg_wdata = 32'h2;
        @(negedge clk);
        host_wr = 1'b0; reg_we = 1'b0; reg_wdata = '0;
        rd_chk("R8 race stat", 8'h04, 32'h2);
        rd_chk("R8 race data", 8'h14, 32'h0000_8866);
        wr(8'h04, 32'h3);
    endtask

    task automatic t_shared();
        wr(8'h10, 32'h0080_0080);
        hw(16'h0080, 8'h5A);
        rd_chk("R9 shared stat", 8'h04, 32'h3);
        rd_chk("R9 shared data", 8'h14, 32'h0000_5A5A);
        wr(8'h04, 32'h3);
    endtask

    task automatic t_undef();
        wr(8'h08, 32'hFFFF_FFFF);
        rd_chk("R11 undef read", 8'h08, 32'h0);
        rd_chk("R11 undef no side", 8'h10, 32'h0080_0080);
        wr(8'h14, 32'hFFFF_FFFF);
        rd_chk("R11 data read-only", 8'h14, 32'h0000_5A5A);
        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk("R11 ctrl unused bits", 8'h00, 32'h0000_000F);
        wr(8'h80, 32'hFFFF_FFFF);
        rd_chk("R11 den unused bits", 8'h80, 32'h0000_C000);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ports();
        t_capture();
        t_w1c();
        t_irq_enable();
        t_gating();
        t_repeat();
        t_overwrite();
        t_race();
        t_shared();
        t_undef();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule